// File: doc/BRIEF.md
# Two-Channel Compare-Match Interval Timer

This peripheral produces periodic ticks for a processor. It has two independent channels behind a small 16-bit register port. Each channel owns a control/status register, an up-counter and a compare register. A shared run register starts and stops the channels. Each channel has its own prescaler, which divides the peripheral clock by 8, 32, 128 or 512.

When a running channel's counter equals its compare value on a prescaled tick, three things happen together: the counter returns to 0, the channel's match flag sets, and the channel's level interrupt asserts if its enable bit is set. Software can read the counter and the compare register to work out how much of the interval is left. It can poll the flag to see whether a wrap is still waiting to be serviced. It acknowledges a wrap with a read of the control/status register followed by a write-back with the flag bit at 0.

Register offsets (byte addresses on `addr_i`) are fixed, and all registers are 16 bits wide:

| Offset | Register |
|--------|----------|
| 0x0 | run register, shared by both channels |
| 0x2 | channel 0 control/status |
| 0x4 | channel 0 counter |
| 0x6 | channel 0 compare |
| 0x8 | channel 1 control/status |
| 0xA | channel 1 counter |
| 0xC | channel 1 compare |

Top module: `cmpm_timer`

## Requirements
- R1: After reset, every register reads 0, except the two compare registers, which read 0xFFFF.
- R2: In the run register at offset 0x0, bit 0 runs channel 0 and bit 1 runs channel 1. A channel whose bit is clear does not count.
- R3: Control/status bits [1:0] hold a value k. The counter then advances once every 8<<(2k) clocks. Its first advance comes exactly that many clocks after the edge that sets the channel's run bit.
- R4: On a tick where the counter equals the compare value, the counter goes to 0 and the flag (control/status bit 7) sets. The period is therefore (compare+1) ticks.
- R5: irq_o[n] is high exactly while channel n has both its flag and its enable (control/status bit 6) at 1.
- R6: Writing 1 to bit 7 does not change the flag. A write with bit 7 at 0 clears the flag only if the control/status register was read with the flag at 1 after the flag last set.
- R7: If a match falls in the same cycle as a valid clear, the flag stays set. The clear must then be armed again by a new read.
- R8: A counter write takes effect at that edge, even while the channel runs, and the write replaces that cycle's increment.
- R9: Unused bits read 0 and ignore writes: run register bits [15:2], and control/status bits [15:8] and [5:2].
- R10: While a channel is stopped, its counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte offset |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; rdata_o is 0 when low |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| irq_o | output | 2 | Level interrupt per channel |

## Verification
Two functions can fall in the same cycle: a match setting the flag, and the software write that clears it. To provoke this, the bench uses a compare value of 0 at divide-by-8, so a match lands on every eighth edge after the run write. It arms the clear with a read, and then times the clear write to land on a match edge. It judges the result through irq_o. The flag must still be set after that edge. A second clear with no new read must also leave the flag set. A counter write timed onto a tick edge is checked the same way: the written value must appear with no increment on top.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;
  localparam int CKS_W      = 2;
  localparam int DIV_BASE   = 8;
  localparam int DIV_STEP   = 2;
  localparam int DIV_MAX    = DIV_BASE << (DIV_STEP * ((1 << CKS_W) - 1));
  localparam int PRE_W      = $clog2(DIV_MAX);
  localparam int FLAG_BIT   = 7;
  localparam int IE_BIT     = 6;
  localparam int RUN_OFS    = 0;
  localparam int CH_BASE    = 2;
  localparam int CH_STRIDE  = 6;
  localparam int CNT_OFS    = 2;
  localparam int CMP_OFS    = 4;
endpackage

// File: rtl/cmpm_prescaler.sv
module cmpm_prescaler
  import cmpm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CKS_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  int unsigned      div;

  always_comb begin
    div    = DIV_BASE << (DIV_STEP * int'(sel_i));
    lim    = PRE_W'(div - 1);
    tick_o = run_i && (pre_q >= lim);
  end

  // held at 0 while stopped, so a start always begins a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !tick_o);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
endmodule

// File: rtl/cmpm_channel.sv
module cmpm_channel
  import cmpm_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter logic [15:0] CMP_RST = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              csr_we_i,
  input  logic              csr_re_i,
  input  logic              cnt_we_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] csr_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              irq_o
);
  logic              tick;
  logic              match;
  logic              flag_q, ie_q, armed_q;
  logic [CKS_W-1:0]  cks_q;
  logic [DATA_W-1:0] cnt_q, cmp_q;

  cmpm_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .sel_i  (cks_q),
    .tick_o (tick)
  );

  assign match = tick && !cnt_we_i && (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= DATA_W'(CMP_RST);
    end else begin
      if (cnt_we_i)   cnt_q <= wdata_i;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
      if (cmp_we_i)   cmp_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cks_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (csr_we_i) begin
        cks_q <= wdata_i[CKS_W-1:0];
        ie_q  <= wdata_i[IE_BIT];
      end
      // a match outranks a clear and disarms it
      if (match) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (csr_we_i && !wdata_i[FLAG_BIT]) begin
        if (armed_q) flag_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (csr_re_i && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    csr_o                = '0;
    csr_o[CKS_W-1:0]     = cks_q;
    csr_o[IE_BIT]        = ie_q;
    csr_o[FLAG_BIT]      = flag_q;
  end
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = flag_q & ie_q;

  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_we_i && cnt_q == cmp_q) |=> (cnt_q == '0 && flag_q));
  assert_flag_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick));
  assert_hold_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));
  assert_set_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && wdata_i[FLAG_BIT] && !flag_q && !tick) |=> !flag_q);
  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
  assert_match_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag_q);
endmodule

// File: rtl/cmpm_timer.sv
module cmpm_timer
  import cmpm_pkg::*;
#(
  parameter int          NUM_CH  = 2,
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 4,
  parameter logic [15:0] CMP_RST = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] run_q;
  logic              run_sel;
  logic [DATA_W-1:0] csr_rd [NUM_CH];
  logic [DATA_W-1:0] cnt_rd [NUM_CH];
  logic [DATA_W-1:0] cmp_rd [NUM_CH];

  assign run_sel = (addr_i == ADDR_W'(RUN_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (we_i && run_sel) run_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * ch;
    logic csr_sel, cnt_sel, cmp_sel;
    assign csr_sel = (addr_i == ADDR_W'(BASE));
    assign cnt_sel = (addr_i == ADDR_W'(BASE + CNT_OFS));
    assign cmp_sel = (addr_i == ADDR_W'(BASE + CMP_OFS));

    cmpm_channel #(
      .DATA_W  (DATA_W),
      .CMP_RST (CMP_RST)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[ch]),
      .csr_we_i (we_i && csr_sel),
      .csr_re_i (re_i && csr_sel),
      .cnt_we_i (we_i && cnt_sel),
      .cmp_we_i (we_i && cmp_sel),
      .wdata_i  (wdata_i),
      .csr_o    (csr_rd[ch]),
      .cnt_o    (cnt_rd[ch]),
      .cmp_o    (cmp_rd[ch]),
      .irq_o    (irq_o[ch])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (run_sel) rdata_o = DATA_W'(run_q);
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i))           rdata_o = csr_rd[i];
        if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + CNT_OFS)) rdata_o = cnt_rd[i];
        if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + CMP_OFS)) rdata_o = cmp_rd[i];
      end
    end
  end

  assert_run_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && run_sel) |=> (run_q == $past(wdata_i[NUM_CH-1:0])));
  assert_irq_only_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> csr_rd[0][FLAG_BIT]);
endmodule

// File: tb/cmpm_timer_test.sv
module cmpm_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  irq_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  cmpm_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .re_i(re_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk_i);
  endtask

  // stop everything, drop any pending flag, load a channel
  task automatic setup_ch(int ch, logic [15:0] csr, logic [15:0] cnt, logic [15:0] cmp);
    logic [15:0] d;
    logic [3:0]  b;
    b = 4'(2 + 6 * ch);
    wr(4'h0, 16'h0);
    rd(b, d);
    wr(b, csr & 16'hFF7F);
    wr(b + 4'd2, cnt);
    wr(b + 4'd4, cmp);
  endtask

  task automatic sweep(int ch, int k, int cmpv);
    int n;
    logic [15:0] d;
    logic [3:0]  b;
    n = 8 << (2 * k);
    b = 4'(2 + 6 * ch);
    setup_ch(ch, 16'(k), 16'h0, 16'(cmpv));
    wr(4'h0, 16'(1 << ch));
    addr_i = b + 4'd2; re_i = 1'b1;
    for (int i = 0; i < n * (cmpv + 2); i++) begin
      #1 chk("R3/R4 count", int'(rdata_o), (i / n) % (cmpv + 1));
      @(negedge clk_i);
    end
    re_i = 1'b0;
    rd(b, d);
    chk("R4 flag after wrap", int'(d[7]), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v;
    int e0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    for (int a = 0; a <= 12; a += 2) begin
      rd(4'(a), d);
      chk("R1 reset", int'(d), (a == 6 || a == 12) ? 16'hFFFF : 0);
    end
    chk("R1 irq reset", int'(irq_o), 0);

    // R9 / R2 unused bits
    wr(4'h0, 16'hFFFF);
    rd(4'h0, d);
    chk("R9 run reg bits", int'(d), 3);
    wr(4'h0, 16'h0);
    wr(4'h2, 16'hFFFF);
    rd(4'h2, d);
    chk("R9 csr bits, R6 set ignored", int'(d), 16'h0043);
    wr(4'h2, 16'h0);

    // R3 / R4 sweeps over all divide settings, both channels
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 4; k++)
        sweep(ch, k, (k == 0) ? 5 : 2);

    // R7 collision: match every 8th edge, clear lands on a match edge
    setup_ch(0, 16'h0040, 16'h0, 16'h0);
    wr(4'h0, 16'h1);
    e0 = cyc;
    wait_cyc(e0 + 9);
    addr_i = 4'h2; re_i = 1'b1;
    #1 chk("R4 flag set", int'(rdata_o[7]), 1);
    @(negedge clk_i); re_i = 1'b0;
    wait_cyc(e0 + 15);
    addr_i = 4'h2; wdata_i = 16'h0040; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    #1 chk("R7 match beats clear", int'(irq_o[0]), 1);
    wait_cyc(e0 + 17);
    we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    #1 chk("R7 disarmed by match, R6", int'(irq_o[0]), 1);
    wr(4'h0, 16'h0);
    rd(4'h2, d);
    wr(4'h2, 16'h0040);
    #1 chk("R6 read then clear, R5", int'(irq_o[0]), 0);

    // R8 counter write on a tick edge; R2 channel 0 idle
    rd(4'h4, v);
    setup_ch(1, 16'h0000, 16'h0, 16'hFFFF);
    wr(4'h0, 16'h2);
    e0 = cyc;
    wait_cyc(e0 + 7);
    addr_i = 4'hA; wdata_i = 16'd100; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; re_i = 1'b1;
    #1 chk("R8 write replaces tick", int'(rdata_o), 100);
    wait_cyc(e0 + 15);
    #1 chk("R8 held until next tick", int'(rdata_o), 100);
    wait_cyc(e0 + 16);
    #1 chk("R8 next tick increments", int'(rdata_o), 101);
    re_i = 1'b0;
    rd(4'h4, d);
    chk("R2 stopped channel 0 idle", int'(d), int'(v));

    // R10 hold while stopped
    wr(4'h0, 16'h0);
    rd(4'hA, v);
    repeat (100) @(negedge clk_i);
    rd(4'hA, d);
    chk("R10 hold", int'(d), int'(v));

    // R5 / R6 on channel 1
    setup_ch(1, 16'h0000, 16'h0, 16'h0);
    wr(4'h0, 16'h2);
    repeat (20) @(negedge clk_i);
    wr(4'h0, 16'h0);
    chk("R5 no irq when disabled", int'(irq_o[1]), 0);
    rd(4'h8, d);
    chk("R4 ch1 flag", int'(d[7]), 1);
    wr(4'h8, 16'h00C0);
    #1 chk("R6 write-one keeps flag, R5", int'(irq_o[1]), 1);
    wr(4'h8, 16'h0040);
    #1 chk("R6 armed clear", int'(irq_o[1]), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule